// File: doc/BRIEF.md
# Shift Queue with Entry Cancellation

This block is a small first-in first-out buffer. It holds its entries in a chain of slots that shift one place toward the head each time the oldest entry leaves. A producer pushes through a ready/valid enqueue port and a consumer pops through a ready/valid dequeue port. Both can complete in the same cycle, so an entry can pass through every cycle with no empty cycle in the stream, even when every slot is full.

A side-band cancel port lets an outside agent withdraw entries that are still waiting. It carries a strobe and one mask bit per slot. Bit k names the k-th oldest entry, so bit 0 is the head. A cancelled entry keeps its slot until it reaches the head. There it is dropped by the queue itself, one per cycle, and the consumer never sees it. If the newest entry is cancelled in the same cycle a new entry arrives, the new entry takes over that slot instead of growing the queue. The dequeue-valid output is driven only from registered state, so a cancel never reaches it within the same cycle.

Top module: `inval_shift_queue`

## Requirements
- R1: When `rst` is high at a clock edge, all entries are emptied. After that edge `deqValid` is 0 and `enqReady` is 1.
- R2: While `invValid` stays low, entries leave through `deqData` in the order they were accepted. Enqueues may be accepted while older entries are still waiting.
- R3: An enqueue and a dequeue in the same cycle both complete, and the next entry is presented in the following cycle. With a full queue, `enqReady` is 1 in any cycle where `deqValid` and `deqReady` are both 1, and this includes a queue with a single slot.
- R4: A dequeue handshake (`deqValid` and `deqReady` both 1) completes even if `invMask[0]` and `invValid` are set in the same cycle. `deqValid` in that cycle depends only on state held from earlier cycles.
- R5: With `invValid` high, mask bit k set cancels the k-th oldest entry (bit 0 is the head). A cancelled entry is never presented with `deqValid` high.
- R6: A cancelled entry at the head is removed at the next clock edge without `deqReady`, one per cycle. A head cancelled through `invMask[0]` is removed at the same edge the cancel is applied. Example: three entries with mask 0b0011 cancelled leave the third entry presented after two edges.
- R7: If the newest entry is cancelled in the cycle an enqueue is accepted, and that slot does not leave the queue at the same edge, the new entry is written into that slot and the number of occupied slots does not grow.
- R8: Mask bits that refer to unoccupied slots have no effect.
- R9: `enqReady` is 0 only when every slot is occupied and no entry leaves the head in that cycle. An entry leaves the head through a dequeue handshake, a discard of a dead head, or a cancel of the head.
- R10: Once every entry has been dequeued or discarded, `deqValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enqValid | input | 1 | Producer offers an entry |
| enqData | input | WIDTH | Entry payload |
| enqReady | output | 1 | Queue accepts the offered entry this cycle |
| deqValid | output | 1 | A live entry is at the head |
| deqData | output | WIDTH | Payload of the head entry |
| deqReady | input | 1 | Consumer takes the head entry |
| invValid | input | 1 | Cancel strobe |
| invMask | input | DEPTH | Per-slot cancel mask, bit 0 = head |

## Verification
The hardest situation to reach from the ports is a cancel that lands on the newest entry while an enqueue is accepted, with older entries still ahead of it. Only then does the new entry overwrite a slot instead of appending, so the stimulus first builds two or more waiting entries with `deqReady` low before it raises the tail bit and `enqValid` together. The bench then drains the queue to show that the overwritten entry is gone and the new one sits in its place. The same method is used for a head that is cancelled and dequeued in the same cycle, and for a cancel of the head while the queue is full.

// File: rtl/shq_pkg.sv
package shq_pkg;

  // Strobes from the control to the slot datapath for one cycle.
  typedef struct packed {
    logic pop;        // every slot moves one place toward the head
    logic push;       // an entry is written at the write index
    logic overwrite;  // the write reuses the cancelled newest slot
  } shqStrobes_t;

  function automatic int idxWidth(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/shq_ctrl.sv
module shq_ctrl
  import shq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = idxWidth(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enqValid,
  input  logic              deqReady,
  input  logic              invValid,
  input  logic [DEPTH-1:0]  invMask,
  input  logic              headLive,
  output logic              enqReady,
  output logic              deqValid,
  output shqStrobes_t       strobes,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DEPTH-1:0]  killMask,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [DEPTH-1:0] occMask;
  logic             notEmpty;
  logic             pop;
  logic             push;
  logic             tailKill;
  logic             overwrite;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] countNext;
  logic [IDX_W-1:0] tailIdx;

  // Slots below the occupancy count hold entries.
  for (genvar k = 0; k < DEPTH; k++) begin : g_occ
    assign occMask[k] = (CNT_W'(k) < count);
  end

  always_comb begin
    killMask  = invValid ? (invMask & occMask) : '0;
    notEmpty  = (count != '0);
    deqValid  = notEmpty && headLive;
    // The head leaves on a handshake, when it is already dead, or when cancelled now.
    pop       = notEmpty && (deqReady || !headLive || killMask[0]);
    enqReady  = (count != FULL_CNT) || pop;
    push      = enqValid && enqReady;
    tailIdx   = IDX_W'(count - ONE_CNT);
    tailKill  = notEmpty && killMask[tailIdx];
    // The cancelled newest slot is reused only if it survives this edge's shift.
    overwrite = push && tailKill && ((count > ONE_CNT) || !pop);
    base      = count - CNT_W'(pop);
    wrIdx     = overwrite ? IDX_W'(base - ONE_CNT) : IDX_W'(base);
    countNext = base + CNT_W'(push && !overwrite);
    strobes.pop       = pop;
    strobes.push      = push;
    strobes.overwrite = overwrite;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= countNext;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R9

  AST_EMPTY_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!notEmpty && !enqValid) |=> (count == '0)); // R8

  AST_DEAD_HEAD_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (notEmpty && !headLive && !enqValid) |=> (count == $past(count) - ONE_CNT)); // R6

  AST_OVERWRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (overwrite && !pop) |=> (count == $past(count))); // R7

endmodule

// File: rtl/shq_data.sv
module shq_data
  import shq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int IDX_W = idxWidth(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  shqStrobes_t       strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DEPTH-1:0]  killMask,
  input  logic [WIDTH-1:0]  enqData,
  output logic              headLive,
  output logic [WIDTH-1:0]  headData,
  output logic [DEPTH-1:0]  liveVec
);

  logic [WIDTH-1:0] slotData [DEPTH];
  logic [DEPTH-1:0] slotLive;
  logic [WIDTH-1:0] srcData  [DEPTH];
  logic [DEPTH-1:0] srcLive;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    // Source of each slot after this edge's shift, with cancels applied.
    if (i < DEPTH - 1) begin : g_mid
      assign srcData[i] = strobes.pop ? slotData[i+1] : slotData[i];
      assign srcLive[i] = strobes.pop ? (slotLive[i+1] && !killMask[i+1])
                                      : (slotLive[i] && !killMask[i]);
    end else begin : g_last
      assign srcData[i] = strobes.pop ? '0 : slotData[i];
      assign srcLive[i] = strobes.pop ? 1'b0 : (slotLive[i] && !killMask[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slotData[i] <= '0;
        slotLive[i] <= 1'b0;
      end else if (strobes.push && (wrIdx == IDX_W'(i))) begin
        slotData[i] <= enqData;
        slotLive[i] <= 1'b1;
      end else begin
        slotData[i] <= srcData[i];
        slotLive[i] <= srcLive[i];
      end
    end
  end

  assign headLive = slotLive[0];
  assign headData = slotData[0];
  assign liveVec  = slotLive;

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
    strobes.push |=> (slotLive[$past(wrIdx)] && (slotData[$past(wrIdx)] == $past(enqData)))); // R7

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (killMask[DEPTH-1] && !strobes.pop && !(strobes.push && (wrIdx == IDX_W'(DEPTH-1))))
      |=> !slotLive[DEPTH-1]); // R5

endmodule

// File: rtl/inval_shift_queue.sv
module inval_shift_queue
  import shq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enqValid,
  input  logic [WIDTH-1:0] enqData,
  output logic             enqReady,
  output logic             deqValid,
  output logic [WIDTH-1:0] deqData,
  input  logic             deqReady,
  input  logic             invValid,
  input  logic [DEPTH-1:0] invMask
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = idxWidth(DEPTH);

  shqStrobes_t      strobes;
  logic [IDX_W-1:0] wrIdx;
  logic [DEPTH-1:0] killMask;
  logic [CNT_W-1:0] count;
  logic             headLive;
  logic [DEPTH-1:0] liveVec;
  logic [DEPTH-1:0] strayLive;

  shq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enqValid (enqValid),
    .deqReady (deqReady),
    .invValid (invValid),
    .invMask  (invMask),
    .headLive (headLive),
    .enqReady (enqReady),
    .deqValid (deqValid),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .killMask (killMask),
    .count    (count)
  );

  shq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .killMask (killMask),
    .enqData  (enqData),
    .headLive (headLive),
    .headData (deqData),
    .liveVec  (liveVec)
  );

  // Live flags at or above the occupancy count would be stale entries.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stray
    assign strayLive[k] = liveVec[k] && !(CNT_W'(k) < count);
  end

  AST_LIVE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    strayLive == '0); // R10

  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
    (deqValid && !deqReady && !(invValid && invMask[0])) |=> (deqValid && $stable(deqData))); // R2

  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (deqValid && deqReady) |-> enqReady); // R3

endmodule

// File: tb/inval_shift_queue_test.sv
module inval_shift_queue_test;

  localparam int WD_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       enqValid, deqReady, invValid;
  logic [7:0] enqData;
  logic [3:0] invMask;
  logic       enqReady, deqValid;
  logic [7:0] deqData;

  logic       enqValid1, deqReady1, invValid1;
  logic [7:0] enqData1;
  logic [0:0] invMask1;
  logic       enqReady1, deqValid1;
  logic [7:0] deqData1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  inval_shift_queue #(.DEPTH(4), .WIDTH(8)) uut (
    .clk(clk), .rst(rst), .enqValid(enqValid), .enqData(enqData), .enqReady(enqReady),
    .deqValid(deqValid), .deqData(deqData), .deqReady(deqReady),
    .invValid(invValid), .invMask(invMask)
  );

  inval_shift_queue #(.DEPTH(1), .WIDTH(8)) uutD1 (
    .clk(clk), .rst(rst), .enqValid(enqValid1), .enqData(enqData1), .enqReady(enqReady1),
    .deqValid(deqValid1), .deqData(deqData1), .deqReady(deqReady1),
    .invValid(invValid1), .invMask(invMask1)
  );

  // Vector: {req, ev, ed, dr, iv, im, expDv, expDd, expEr}
  function automatic logic [28:0] mk(input logic [3:0] rq, input logic ev, input logic [7:0] ed,
                                     input logic dr, input logic iv, input logic [3:0] im,
                                     input logic dv, input logic [7:0] dd, input logic er);
    return {rq, ev, ed, dr, iv, im, dv, dd, er};
  endfunction

  function automatic string reqName(input logic [3:0] rq);
    case (rq)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R1";
    endcase
  endfunction

  localparam int NVEC = 48;
  localparam logic [28:0] VEC [NVEC] = '{
    mk(2, 1,8'h11, 0,0,4'h0, 0,8'h00, 1),  // fill, R2
    mk(2, 1,8'h22, 0,0,4'h0, 1,8'h11, 1),
    mk(2, 1,8'h33, 0,0,4'h0, 1,8'h11, 1),
    mk(2, 1,8'h44, 0,0,4'h0, 1,8'h11, 1),
    mk(9, 1,8'h55, 0,0,4'h0, 1,8'h11, 0),  // full, no pop: R9
    mk(3, 1,8'h55, 1,0,4'h0, 1,8'h11, 1),  // full pass-through: R3
    mk(2, 0,8'h00, 1,0,4'h0, 1,8'h22, 1),
    mk(2, 0,8'h00, 1,0,4'h0, 1,8'h33, 1),
    mk(2, 0,8'h00, 1,0,4'h0, 1,8'h44, 1),
    mk(2, 0,8'h00, 1,0,4'h0, 1,8'h55, 1),
    mk(10,0,8'h00, 1,0,4'h0, 0,8'h00, 1),  // empty: R10
    mk(8, 1,8'h66, 0,1,4'hF, 0,8'h00, 1),  // mask on empty slots: R8
    mk(8, 1,8'h77, 0,0,4'h0, 1,8'h66, 1),
    mk(2, 1,8'h88, 0,0,4'h0, 1,8'h66, 1),
    mk(5, 0,8'h00, 0,1,4'h3, 1,8'h66, 1),  // cancel two oldest: R5
    mk(6, 0,8'h00, 0,0,4'h0, 0,8'h00, 1),  // dead head drains: R6
    mk(6, 0,8'h00, 1,0,4'h0, 1,8'h88, 1),
    mk(2, 1,8'h99, 0,0,4'h0, 0,8'h00, 1),
    mk(4, 1,8'hAA, 1,1,4'h1, 1,8'h99, 1),  // cancel head while dequeued: R4
    mk(4, 0,8'h00, 1,0,4'h0, 1,8'hAA, 1),
    mk(2, 1,8'hB1, 0,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hB2, 0,0,4'h0, 1,8'hB1, 1),
    mk(7, 1,8'hB3, 0,1,4'h2, 1,8'hB1, 1),  // tail overwrite: R7
    mk(7, 0,8'h00, 1,0,4'h0, 1,8'hB1, 1),
    mk(7, 0,8'h00, 1,0,4'h0, 1,8'hB3, 1),
    mk(10,0,8'h00, 1,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hC1, 0,0,4'h0, 0,8'h00, 1),
    mk(7, 1,8'hC2, 0,1,4'h1, 1,8'hC1, 1),  // single entry cancelled with enqueue: R7
    mk(7, 0,8'h00, 1,0,4'h0, 1,8'hC2, 1),
    mk(10,0,8'h00, 1,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hD1, 0,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hD2, 0,0,4'h0, 1,8'hD1, 1),
    mk(2, 1,8'hD3, 0,0,4'h0, 1,8'hD1, 1),
    mk(5, 0,8'h00, 0,1,4'h2, 1,8'hD1, 1),  // cancel middle entry: R5
    mk(5, 0,8'h00, 1,0,4'h0, 1,8'hD1, 1),
    mk(6, 0,8'h00, 1,0,4'h0, 0,8'h00, 1),  // dead head hidden then dropped: R6
    mk(5, 0,8'h00, 1,0,4'h0, 1,8'hD3, 1),
    mk(10,0,8'h00, 1,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hE1, 0,0,4'h0, 0,8'h00, 1),
    mk(2, 1,8'hE2, 0,0,4'h0, 1,8'hE1, 1),
    mk(2, 1,8'hE3, 0,0,4'h0, 1,8'hE1, 1),
    mk(2, 1,8'hE4, 0,0,4'h0, 1,8'hE1, 1),
    mk(9, 1,8'hE5, 0,1,4'h1, 1,8'hE1, 1),  // full, head cancel frees a slot: R9
    mk(9, 0,8'h00, 1,0,4'h0, 1,8'hE2, 1),
    mk(9, 0,8'h00, 1,0,4'h0, 1,8'hE3, 1),
    mk(9, 0,8'h00, 1,0,4'h0, 1,8'hE4, 1),
    mk(9, 0,8'h00, 1,0,4'h0, 1,8'hE5, 1),
    mk(10,0,8'h00, 1,0,4'h0, 0,8'h00, 1)
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    enqValid = 0; enqData = '0; deqReady = 0; invValid = 0; invMask = '0;
    enqValid1 = 0; enqData1 = '0; deqReady1 = 0; invValid1 = 0; invMask1 = '0;
  endtask

  initial begin
    #(WD_CYCLES * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "deqValid after reset", deqValid, 0);
    chk("R1", "enqReady after reset", enqReady, 1);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      enqValid = VEC[v][24];
      enqData  = VEC[v][23:16];
      deqReady = VEC[v][15];
      invValid = VEC[v][14];
      invMask  = VEC[v][13:10];
      #1;
      chk(reqName(VEC[v][28:25]), $sformatf("vec %0d deqValid", v), deqValid, VEC[v][9]);
      chk(reqName(VEC[v][28:25]), $sformatf("vec %0d enqReady", v), enqReady, VEC[v][0]);
      if (VEC[v][9])
        chk(reqName(VEC[v][28:25]), $sformatf("vec %0d deqData", v), deqData, VEC[v][8:1]);
    end

    // Single-slot queue: full hand-over in one cycle (R3)
    @(negedge clk); idleInputs(); enqValid1 = 1; enqData1 = 8'h5A;
    #1 chk("R3", "d1 empty enqReady", enqReady1, 1);
    @(negedge clk); enqValid1 = 1; enqData1 = 8'h5B; deqReady1 = 0;
    #1 chk("R3", "d1 full no pop enqReady", enqReady1, 0);
    @(negedge clk); enqValid1 = 1; enqData1 = 8'h5B; deqReady1 = 1;
    #1 chk("R3", "d1 full pop enqReady", enqReady1, 1);
    chk("R3", "d1 head", deqData1, 8'h5A);
    @(negedge clk); enqValid1 = 1; enqData1 = 8'h5C; deqReady1 = 1;
    #1 chk("R3", "d1 next head no bubble", deqValid1, 1);
    chk("R3", "d1 next data", deqData1, 8'h5B);
    @(negedge clk); enqValid1 = 0; deqReady1 = 1;
    #1 chk("R3", "d1 last data", deqData1, 8'h5C);
    @(negedge clk);
    #1 chk("R10", "d1 empty", deqValid1, 0);

    // Reset in the middle of traffic empties the queue (R1)
    @(negedge clk); idleInputs(); enqValid = 1; enqData = 8'hF1;
    @(negedge clk); enqData = 8'hF2;
    @(negedge clk); enqValid = 0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk("R1", "deqValid after mid reset", deqValid, 0);
    chk("R1", "enqReady after mid reset", enqReady, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule